// File: doc/BRIEF.md
# Scan Clock Edge Wait and Sync Monitor

This block sits beside fabric logic that exchanges data with a host across a slow, externally generated scan clock. That clock is high while the host is idle, which is the safe window for touching shared data. It is low while the host is moving data. The block brings the scan clock and an engine-running flag into the local clock domain. It shows the synchronized scan level as a coherency-safe indicator.

A requester pulses `start_i` together with a signed tick count in `timeout_i`. The block then waits for the next rising edge of the scan clock or for the timeout, whichever comes first. It reports the result with a one-cycle `done_o` pulse. `timed_out_o` and two missed-edge flags are valid from that pulse and hold until the next completion. The missed-edge flags tell the requester whether it fell out of step with the scan clock between two requests.

The block also measures how many local ticks the scan clock stayed high during its last complete period. It reports that count at all times.

The request interface carries no data stream. `start_i` is a plain control pulse with no back-pressure. `busy_o` shows when a pulse would be dropped. Every status pin is a plain level.

Top module: `scan_wait_mon`

## Requirements
- R1: `scan_level_o` follows `scan_clk_i` through two local flops. A change driven before clock edge k shows at the output after edge k+1. High means no host transfer is in progress. Both synchronized levels read 0 in reset.
- R2: A request is accepted on an edge where `start_i` is 1 and `busy_o` is 0. While `busy_o` is 1, `start_i` is ignored and does not change the completion time or the flags of the wait in progress. `busy_o` is 0 in the cycle `done_o` is high.
- R3: A timeout of 0 completes on the accepting edge, with `done_o` and `timed_out_o` both 1 in the following cycle.
- R4: A positive timeout T with no rising scan edge completes T edges after the accepting edge, with `timed_out_o` = 1.
- R5: A rising edge of the synchronized scan level while a wait is active completes it on the next edge, with `timed_out_o` = 0. A negative timeout never expires.
- R6: When the rising edge and the expiry of a positive timeout fall on the same edge, the result is `timed_out_o` = 0.
- R7: `missed_fall_o` is 1 if at least one falling edge of the synchronized scan level occurred after the previous completion, up to and including the accepting cycle of the current request. `missed_rise_o` follows the same rule for rising edges. Edges seen while a wait is active are not counted.
- R8: The first request after reset reports both missed-edge flags as 0.
- R9: `high_time_o` holds the number of local cycles the synchronized scan level was high in the last period that ended with a rising edge. It reads 0 until the second rising edge after reset or after an enable.
- R10: The high-time count saturates at 2^HTW-1 instead of wrapping.
- R11: `scan_enabled_o` follows `engine_run_i` through two local flops. While it is 0, `high_time_o` is cleared to 0 on the next edge and the period measurement restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_clk_i | input | 1 | Asynchronous scan clock from the host side |
| engine_run_i | input | 1 | Asynchronous engine-running flag from the host side |
| start_i | input | 1 | Wait request pulse |
| timeout_i | input | TW | Signed timeout in local ticks, sampled with the request |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timed_out_o | output | 1 | Last wait ended by timeout |
| missed_fall_o | output | 1 | Falling scan edge seen between requests |
| missed_rise_o | output | 1 | Rising scan edge seen between requests |
| high_time_o | output | HTW | High ticks of the last complete scan period |
| scan_level_o | output | 1 | Synchronized scan level (1 = safe to access data) |
| scan_enabled_o | output | 1 | Synchronized engine-running status |

## Verification
A wrong remaining-tick count or a wrong infinite-wait flag moves the `done_o` pulse by at least one cycle, or makes it never arrive. The bench measures the completion cycle exactly, so the error shows on the first request that uses that timeout. A stuck or wrongly cleared edge-history bit shows as a wrong missed flag on the request right after the idle gap in which it went wrong. A faulty high-time counter or period-seen bit shows on `high_time_o` within three cycles after the next synchronized rising edge.

// File: rtl/scan_wait_pkg.sv
package scan_wait_pkg;
  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_WAIT = 1'b1
  } wait_state_e;

  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/scan_sync_chain.sv
module scan_sync_chain #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/scan_edge_det.sv
module scan_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/scan_high_timer.sv
module scan_high_timer #(
  parameter int HTW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           level_i,
  input  logic           rise_i,
  output logic [HTW-1:0] high_time_o
);
  localparam logic [HTW-1:0] CNT_MAX = '1;
  localparam logic [HTW-1:0] CNT_ONE = HTW'(1);

  logic [HTW-1:0] cnt_q;
  logic           seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      seen_q      <= 1'b0;
      high_time_o <= '0;
    end else if (!en_i) begin
      cnt_q       <= '0;
      seen_q      <= 1'b0;
      high_time_o <= '0;
    end else if (rise_i) begin
      if (seen_q) high_time_o <= cnt_q;
      seen_q <= 1'b1;
      cnt_q  <= CNT_ONE;
    end else if (level_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end
endmodule

// File: rtl/scan_wait_ctrl.sv
module scan_wait_ctrl
  import scan_wait_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic signed [TW-1:0] timeout_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 timed_out_o,
  output logic                 miss_fall_o,
  output logic                 miss_rise_o
);
  localparam logic [TW-1:0] REM_ONE = TW'(1);

  wait_state_e   st_q;
  logic [TW-1:0] rem_q;
  logic          endless_q;
  logic          had_prev_q;
  logic          fall_seen_q;
  logic          rise_seen_q;
  logic          accept;
  logic          expire;

  assign accept = start_i && (st_q == WS_IDLE);
  assign expire = (st_q == WS_WAIT) && !endless_q && (rem_q == REM_ONE);
  assign busy_o = (st_q == WS_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= WS_IDLE;
      rem_q       <= '0;
      endless_q   <= 1'b0;
      had_prev_q  <= 1'b0;
      fall_seen_q <= 1'b0;
      rise_seen_q <= 1'b0;
      done_o      <= 1'b0;
      timed_out_o <= 1'b0;
      miss_fall_o <= 1'b0;
      miss_rise_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        fall_seen_q <= 1'b0;
        rise_seen_q <= 1'b0;
        miss_fall_o <= had_prev_q & (fall_seen_q | fall_i);
        miss_rise_o <= had_prev_q & (rise_seen_q | rise_i);
        if (timeout_i == '0) begin
          done_o      <= 1'b1;
          timed_out_o <= 1'b1;
          had_prev_q  <= 1'b1;
        end else begin
          st_q      <= WS_WAIT;
          endless_q <= timeout_i[TW-1];
          rem_q     <= timeout_i;
        end
      end else if (st_q == WS_IDLE) begin
        if (had_prev_q && fall_i) fall_seen_q <= 1'b1;
        if (had_prev_q && rise_i) rise_seen_q <= 1'b1;
      end else if (rise_i) begin
        st_q        <= WS_IDLE;
        done_o      <= 1'b1;
        timed_out_o <= 1'b0;
        had_prev_q  <= 1'b1;
      end else if (expire) begin
        st_q        <= WS_IDLE;
        done_o      <= 1'b1;
        timed_out_o <= 1'b1;
        had_prev_q  <= 1'b1;
      end else if (!endless_q) begin
        rem_q <= rem_q - REM_ONE;
      end
    end
  end
endmodule

// File: rtl/scan_wait_mon.sv
module scan_wait_mon
  import scan_wait_pkg::*;
#(
  parameter int TW          = 16,
  parameter int HTW         = 16,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_clk_i,
  input  logic                 engine_run_i,
  input  logic                 start_i,
  input  logic signed [TW-1:0] timeout_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 timed_out_o,
  output logic                 missed_fall_o,
  output logic                 missed_rise_o,
  output logic [HTW-1:0]       high_time_o,
  output logic                 scan_level_o,
  output logic                 scan_enabled_o
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_q;
  logic              lvl_s;
  logic              en_s;
  logic              rise_s;
  logic              fall_s;

  scan_sync_chain #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({engine_run_i, scan_clk_i}),
    .q_o   (sync_q)
  );

  assign lvl_s          = sync_q[0];
  assign en_s           = sync_q[1];
  assign scan_level_o   = lvl_s;
  assign scan_enabled_o = en_s;

  scan_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_s),
    .rise_o (rise_s),
    .fall_o (fall_s)
  );

  scan_wait_ctrl #(.TW(TW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .timeout_i   (timeout_i),
    .rise_i      (rise_s),
    .fall_i      (fall_s),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timed_out_o (timed_out_o),
    .miss_fall_o (missed_fall_o),
    .miss_rise_o (missed_rise_o)
  );

  scan_high_timer #(.HTW(HTW)) u_high (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_s),
    .level_i     (lvl_s),
    .rise_i      (rise_s),
    .high_time_o (high_time_o)
  );
endmodule

// File: rtl/scan_wait_mon_chk.sv
module scan_wait_mon_chk #(
  parameter int TW  = 16,
  parameter int HTW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic signed [TW-1:0] timeout_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 timed_out_o,
  input logic                 missed_fall_o,
  input logic                 missed_rise_o,
  input logic [HTW-1:0]       high_time_o,
  input logic                 scan_level_o,
  input logic                 scan_enabled_o
);
  logic seen_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_done_q <= 1'b0;
    else if (done_o) seen_done_q <= 1'b1;
  end

  // R3
  a_r3_zero_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && timeout_i == '0) |=> (done_o && timed_out_o));

  // R2
  a_r2_accept_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && timeout_i != '0) |=> (busy_o && !done_o));

  // R2
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R5, R6
  a_r5_rise_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $rose(scan_level_o)) |=> (done_o && !timed_out_o));

  // R8
  a_r8_first_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !seen_done_q) |-> (!missed_fall_o && !missed_rise_o));

  // R11
  a_r11_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_enabled_o |=> (high_time_o == '0));
endmodule

bind scan_wait_mon scan_wait_mon_chk #(.TW(TW), .HTW(HTW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .timeout_i      (timeout_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .timed_out_o    (timed_out_o),
  .missed_fall_o  (missed_fall_o),
  .missed_rise_o  (missed_rise_o),
  .high_time_o    (high_time_o),
  .scan_level_o   (scan_level_o),
  .scan_enabled_o (scan_enabled_o)
);

// File: tb/scan_wait_mon_tb.sv
module scan_wait_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW         = 16;
  localparam int HTW        = 8;
  localparam int WD_LIMIT   = 150000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 scan_clk_r = 1'b0;
  logic                 run_r = 1'b0;
  logic                 start_r = 1'b0;
  logic signed [TW-1:0] timeout_r = '0;
  logic                 busy_o, done_o, timed_out_o, missed_fall_o, missed_rise_o;
  logic [HTW-1:0]       high_time_o;
  logic                 scan_level_o, scan_enabled_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_wait_mon #(.TW(TW), .HTW(HTW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .scan_clk_i     (scan_clk_r),
    .engine_run_i   (run_r),
    .start_i        (start_r),
    .timeout_i      (timeout_r),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .timed_out_o    (timed_out_o),
    .missed_fall_o  (missed_fall_o),
    .missed_rise_o  (missed_rise_o),
    .high_time_o    (high_time_o),
    .scan_level_o   (scan_level_o),
    .scan_enabled_o (scan_enabled_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected cycle (negedge index after start is driven) at which done shows.
  function automatic int exp_done_at(input int tval, input int tog_at);
    if (tval == 0) return 1;
    if (tog_at > 0 && (tval < 0 || tog_at + 3 <= tval + 1)) return tog_at + 3;
    return tval + 1;
  endfunction

  function automatic int exp_tout(input int tval, input int tog_at);
    if (tval == 0) return 1;
    if (tog_at > 0 && (tval < 0 || tog_at + 3 <= tval + 1)) return 0;
    return 1;
  endfunction

  task automatic timed_req(input int tval, input int tog_at, input int spur_at,
                           output int m, output int to, output int mf, output int mr);
    bit got;
    @(negedge clk);
    start_r   = 1'b1;
    timeout_r = TW'(tval);
    m = 0; got = 0; to = -1; mf = -1; mr = -1;
    while (!got && m < 5000) begin
      @(negedge clk);
      m++;
      start_r = 1'b0;
      if (done_o) begin
        got = 1;
        to = int'(timed_out_o);
        mf = int'(missed_fall_o);
        mr = int'(missed_rise_o);
      end else begin
        if (m == tog_at) scan_clk_r = ~scan_clk_r;
        if (spur_at > 0 && m == spur_at) begin
          start_r   = 1'b1;
          timeout_r = '0;
        end
      end
    end
  endtask

  task automatic toggle_settle(inout int ef, inout int er);
    scan_clk_r = ~scan_clk_r;
    if (scan_clk_r) er = 1; else ef = 1;
    wait_n(5);
  endtask

  task automatic gen_period(input int h, input int l);
    scan_clk_r = 1'b1;
    wait_n(h);
    scan_clk_r = 1'b0;
    wait_n(l);
  endtask

  initial begin
    int m, to, mf, mr, ef, er, tval, tog, k, hprev;
    void'($urandom(32'd4242));

    wait_n(3);
    chk("R1 reset level", int'(scan_level_o), 0);
    chk("R11 reset enabled", int'(scan_enabled_o), 0);
    chk("R2 reset busy", int'(busy_o), 0);
    chk("R2 reset done", int'(done_o), 0);
    chk("R9 reset high", int'(high_time_o), 0);
    rst_n = 1'b1;
    wait_n(2);

    // R11 enable synchronizer latency
    run_r = 1'b1;
    wait_n(1);
    chk("R11 enabled after 1", int'(scan_enabled_o), 0);
    wait_n(1);
    chk("R11 enabled after 2", int'(scan_enabled_o), 1);

    // R1 level synchronizer latency
    scan_clk_r = 1'b1;
    wait_n(1);
    chk("R1 level after 1", int'(scan_level_o), 0);
    wait_n(1);
    chk("R1 level after 2", int'(scan_level_o), 1);
    scan_clk_r = 1'b0;
    wait_n(5);

    // R8 and R3: first request, zero timeout
    timed_req(0, 0, 0, m, to, mf, mr);
    chk("R3 zero cycles", m, 1);
    chk("R3 zero timed out", to, 1);
    chk("R8 first fall", mf, 0);
    chk("R8 first rise", mr, 0);

    // R4 positive timeout, no edges between
    wait_n(5);
    timed_req(4, 0, 0, m, to, mf, mr);
    chk("R4 cycles", m, exp_done_at(4, 0));
    chk("R4 timed out", to, 1);
    chk("R7 quiet fall", mf, 0);
    chk("R7 quiet rise", mr, 0);

    // R7 windows
    ef = 0; er = 0; toggle_settle(ef, er);
    timed_req(2, 0, 0, m, to, mf, mr);
    chk("R7 rise only: rise", mr, 1);
    chk("R7 rise only: fall", mf, 0);
    ef = 0; er = 0; toggle_settle(ef, er);
    timed_req(2, 0, 0, m, to, mf, mr);
    chk("R7 fall only: fall", mf, 1);
    chk("R7 fall only: rise", mr, 0);
    ef = 0; er = 0; toggle_settle(ef, er); toggle_settle(ef, er);
    timed_req(2, 0, 0, m, to, mf, mr);
    chk("R7 both: fall", mf, 1);
    chk("R7 both: rise", mr, 1);

    // R6 edge and expiry on the same edge
    timed_req(10, 8, 0, m, to, mf, mr);
    chk("R6 tie cycles", m, 11);
    chk("R6 tie timed out", to, 0);
    chk("R7 in-wait edge not missed", mr, 0);
    ef = 0; er = 0; toggle_settle(ef, er);
    timed_req(10, 9, 0, m, to, mf, mr);
    chk("R6 late edge cycles", m, 11);
    chk("R6 late edge timed out", to, 1);
    chk("R7 late fall", mf, 1);

    // R2 start while busy is ignored (rise after previous timeout is missed)
    wait_n(5);
    timed_req(20, 0, 5, m, to, mf, mr);
    chk("R2 ignored cycles", m, 21);
    chk("R2 ignored timed out", to, 1);
    chk("R7 rise after timeout", mr, 1);
    k = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (done_o) k++;
    end
    chk("R2 no extra done", k, 0);

    // R5 negative timeout waits indefinitely
    ef = 0; er = 0; toggle_settle(ef, er);
    timed_req(-1, 60, 0, m, to, mf, mr);
    chk("R5 negative cycles", m, exp_done_at(-1, 60));
    chk("R5 negative timed out", to, 0);
    chk("R7 before negative: fall", mf, 1);
    ef = 0; er = 0; toggle_settle(ef, er);
    timed_req(1000, 20, 0, m, to, mf, mr);
    chk("R5 long positive cycles", m, 23);
    chk("R5 long positive timed out", to, 0);

    // Random requests
    for (int it = 0; it < 30; it++) begin
      ef = 0; er = 0;
      k = int'($urandom_range(0, 3));
      for (int j = 0; j < k; j++) toggle_settle(ef, er);
      if ($urandom_range(0, 1) == 0) begin
        tval = int'($urandom_range(0, 40));
        tog  = 0;
      end else begin
        if (scan_clk_r) toggle_settle(ef, er);
        tog  = int'($urandom_range(3, 40));
        tval = ($urandom_range(0, 1) == 0) ? -int'($urandom_range(1, 100))
                                          : int'($urandom_range(50, 200));
      end
      timed_req(tval, tog, 0, m, to, mf, mr);
      chk("R4/R5 random cycles", m, exp_done_at(tval, tog));
      chk("R4/R5 random timed out", to, exp_tout(tval, tog));
      chk("R7 random fall", mf, ef);
      chk("R7 random rise", mr, er);
    end

    // R9 high time, restart from a disable
    run_r = 1'b0;
    wait_n(4);
    chk("R11 disabled status", int'(scan_enabled_o), 0);
    chk("R11 disabled high", int'(high_time_o), 0);
    run_r = 1'b1;
    scan_clk_r = 1'b0;
    wait_n(5);
    gen_period(7, 5);
    chk("R9 first period zero", int'(high_time_o), 0);
    gen_period(7, 5);
    chk("R9 second period", int'(high_time_o), 7);
    gen_period(3, 9);
    chk("R9 third period", int'(high_time_o), 7);
    gen_period(1, 5);
    chk("R9 short high", int'(high_time_o), 3);

    // R10 saturation
    gen_period(300, 5);
    gen_period(2, 5);
    chk("R10 saturated", int'(high_time_o), 255);
    gen_period(4, 5);
    chk("R9 after saturation", int'(high_time_o), 2);

    // R11 re-enable restarts the measurement
    run_r = 1'b0;
    wait_n(4);
    chk("R11 cleared on disable", int'(high_time_o), 0);
    run_r = 1'b1;
    wait_n(4);
    gen_period(6, 4);
    chk("R9 first period after enable", int'(high_time_o), 0);
    gen_period(6, 4);
    chk("R9 second period after enable", int'(high_time_o), 6);

    // Random periods
    hprev = 6;
    for (int it = 0; it < 12; it++) begin
      k = int'($urandom_range(1, 20));
      gen_period(k, int'($urandom_range(3, 20)));
      chk("R9 random period", int'(high_time_o), hprev);
      hprev = k;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule